// File: doc/BRIEF.md
# Boundary Scan Data Register Set

This block holds the test data registers that sit behind a JTAG test access port for a group of bidirectional pins. An external TAP controller supplies the test clock, single-cycle capture, shift and update strobes, and the decoded current instruction. The block supplies the serial output. Each pin owns two scan cells. The cell at the even position handles the pin's output enable. The cell at the odd position just above it handles the pin's data. Each cell has a shift stage and an update latch.

Under the external-test instruction, the pins are driven from the update latches. The core then sees every pin input as logic 1. Under the sample instruction, the register captures the pins and the core's enables, and it can preload the latches, while the core keeps control of the pins. The block also holds a one-bit bypass register and a 32-bit identification register. It routes bit 0 of the selected register to the serial output.

Top module: `bscan_dr`

## Requirements
- R1: On a capture strobe under EXTEST (code 0) or SAMPLE (code 1), shift bit 2n loads `core_oe[n]` and shift bit 2n+1 loads `pad_in[n]`. Capture takes priority over shift in the same cycle.
- R2: On a shift strobe under EXTEST or SAMPLE, the boundary register moves one place toward bit 0, and `tdi` enters bit 2·N_PINS−1. `tdo` shows boundary bit 0 whenever one of these two instructions is selected.
- R3: The update latches load the whole shift register only on an update strobe under EXTEST or SAMPLE. At all other times they hold, so pin outputs do not move during a shift.
- R4: While EXTEST is selected and `trst` is low, `pad_oe[n]` equals update latch 2n and `pad_out[n]` equals update latch 2n+1.
- R5: Under any other instruction, or while `trst` is high, `pad_oe` equals `core_oe` and `pad_out` equals `core_out`.
- R6: While EXTEST is selected and `trst` is low, `core_in` is all ones whatever `pad_in` is. Otherwise `core_in` equals `pad_in`.
- R7: Under SAMPLE, shift and update preset the latches without changing the pins. A later switch to EXTEST drives the preset values.
- R8: BYPASS (code 2) selects the one-bit bypass register. A capture strobe loads 0 into it, a shift strobe loads `tdi` into it, and `tdo` shows it.
- R9: IDCODE (code 3) selects the 32-bit ID register. A capture strobe loads ID_VALUE with bit 0 forced to 1. Shifting sends bit 0 out first on `tdo`.
- R10: A high `trst`, sampled on the rising edge of `tck`, clears all shift stages, update latches, the bypass register and the ID register. While `trst` is high, the core drives every pin.
- R11: Strobes have no effect on registers that the current instruction does not select. For example, boundary cells and latches are unchanged by shift and update strobes under BYPASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst | input | 1 | Synchronous active-high test reset |
| instr | input | 2 | Decoded instruction: 0 EXTEST, 1 SAMPLE, 2 BYPASS, 3 IDCODE |
| cap_dr | input | 1 | Capture strobe from the TAP controller |
| shift_dr | input | 1 | Shift strobe from the TAP controller |
| update_dr | input | 1 | Update strobe from the TAP controller |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out (bit 0 of the selected register) |
| core_oe | input | N_PINS | Output enables presented by the core logic |
| core_out | input | N_PINS | Output values presented by the core logic |
| core_in | output | N_PINS | Pin inputs delivered to the core logic |
| pad_in | input | N_PINS | Levels present on the pins |
| pad_oe | output | N_PINS | Output enables sent to the pad drivers |
| pad_out | output | N_PINS | Output values sent to the pad drivers |

## Verification
The assertions check, on every cycle, the local register behaviour:
- what the boundary cells take on capture,
- which bit `tdi` enters on a shift,
- that the update latches hold unless an update strobe arrives, and load the shift stages when one does,
- that the bypass register and the ID register's bit 0 load correctly on capture.

Only the bench's scenarios can show the sequences that span several instructions. These are a preset made under SAMPLE that appears on the pins only after the switch to EXTEST, latches that survive BYPASS traffic, and the full serial order of captured and ID bits read back on `tdo`.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    typedef enum logic [1:0] {
        INS_EXTEST = 2'd0,
        INS_SAMPLE = 2'd1,
        INS_BYPASS = 2'd2,
        INS_IDCODE = 2'd3
    } instr_e;

    typedef struct packed {
        logic cap;
        logic shf;
        logic upd;
    } strobe_t;

    function automatic logic uses_boundary(instr_e ins);
        return (ins == INS_EXTEST) || (ins == INS_SAMPLE);
    endfunction

    function automatic strobe_t gate_strobes(strobe_t s, logic sel);
        strobe_t g;
        g.cap = s.cap & sel;
        g.shf = s.shf & sel;
        g.upd = s.upd & sel;
        return g;
    endfunction

endpackage

// File: rtl/bscan_chain.sv
module bscan_chain
    import bscan_pkg::*;
#(
    parameter int N_PINS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_t           stb,
    input  logic              tdi,
    input  logic [N_PINS-1:0] core_oe,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] lat_oe,
    output logic [N_PINS-1:0] lat_dat,
    output logic              so
);
    localparam int W = 2 * N_PINS;

    logic [W-1:0]      sr;
    logic [W-1:0]      lat;
    logic [W-1:0]      cap_vec;
    logic [N_PINS-1:0] sr_oe;
    logic [N_PINS-1:0] sr_dat;

    for (genvar n = 0; n < N_PINS; n++) begin : g_pin
        assign cap_vec[2*n]   = core_oe[n];
        assign cap_vec[2*n+1] = pad_in[n];
        assign lat_oe[n]      = lat[2*n];
        assign lat_dat[n]     = lat[2*n+1];
        assign sr_oe[n]       = sr[2*n];
        assign sr_dat[n]      = sr[2*n+1];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (stb.cap) begin
            sr <= cap_vec;
        end else if (stb.shf) begin
            sr <= {tdi, sr[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat <= '0;
        end else if (stb.upd) begin
            lat <= sr;
        end
    end

    assign so = sr[0];

    // R1
    cap_oe_chk: assert property (@(posedge clk) disable iff (rst)
        stb.cap |=> sr_oe == $past(core_oe));

    // R1
    cap_pad_chk: assert property (@(posedge clk) disable iff (rst)
        stb.cap |=> sr_dat == $past(pad_in));

    // R2
    shift_in_chk: assert property (@(posedge clk) disable iff (rst)
        (stb.shf && !stb.cap) |=> sr[W-1] == $past(tdi));

    // R3
    latch_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !stb.upd |=> $stable(lat));

    // R3
    latch_load_chk: assert property (@(posedge clk) disable iff (rst)
        stb.upd |=> lat == $past(sr));

endmodule

// File: rtl/bscan_aux.sv
module bscan_aux
    import bscan_pkg::*;
#(
    parameter logic [31:0] ID_VALUE = 32'h4B1D_0E37
) (
    input  logic    clk,
    input  logic    rst,
    input  strobe_t byp_stb,
    input  strobe_t id_stb,
    input  logic    tdi,
    output logic    byp_so,
    output logic    id_so
);
    localparam logic [31:0] ID_EFF = ID_VALUE | 32'h1;

    logic        byp;
    logic [31:0] id_sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            byp <= 1'b0;
        end else if (byp_stb.cap) begin
            byp <= 1'b0;
        end else if (byp_stb.shf) begin
            byp <= tdi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            id_sr <= '0;
        end else if (id_stb.cap) begin
            id_sr <= ID_EFF;
        end else if (id_stb.shf) begin
            id_sr <= {tdi, id_sr[31:1]};
        end
    end

    assign byp_so = byp;
    assign id_so  = id_sr[0];

    // R8
    byp_cap_chk: assert property (@(posedge clk) disable iff (rst)
        byp_stb.cap |=> !byp);

    // R9
    id_lsb_chk: assert property (@(posedge clk) disable iff (rst)
        id_stb.cap |=> id_sr[0]);

endmodule

// File: rtl/bscan_dr.sv
module bscan_dr
    import bscan_pkg::*;
#(
    parameter int          N_PINS   = 8,
    parameter logic [31:0] ID_VALUE = 32'h4B1D_0E37
) (
    input  logic              tck,
    input  logic              trst,
    input  logic [1:0]        instr,
    input  logic              cap_dr,
    input  logic              shift_dr,
    input  logic              update_dr,
    input  logic              tdi,
    output logic              tdo,
    input  logic [N_PINS-1:0] core_oe,
    input  logic [N_PINS-1:0] core_out,
    output logic [N_PINS-1:0] core_in,
    input  logic [N_PINS-1:0] pad_in,
    output logic [N_PINS-1:0] pad_oe,
    output logic [N_PINS-1:0] pad_out
);
    instr_e            ins;
    strobe_t           raw_stb;
    strobe_t           bnd_stb;
    strobe_t           byp_stb;
    strobe_t           id_stb;
    logic              ext_on;
    logic              bnd_so;
    logic              byp_so;
    logic              id_so;
    logic [N_PINS-1:0] lat_oe;
    logic [N_PINS-1:0] lat_dat;

    assign ins         = instr_e'(instr);
    assign raw_stb.cap = cap_dr;
    assign raw_stb.shf = shift_dr;
    assign raw_stb.upd = update_dr;

    assign bnd_stb = gate_strobes(raw_stb, uses_boundary(ins));
    assign byp_stb = gate_strobes(raw_stb, ins == INS_BYPASS);
    assign id_stb  = gate_strobes(raw_stb, ins == INS_IDCODE);

    bscan_chain #(.N_PINS(N_PINS)) u_chain (
        .clk     (tck),
        .rst     (trst),
        .stb     (bnd_stb),
        .tdi     (tdi),
        .core_oe (core_oe),
        .pad_in  (pad_in),
        .lat_oe  (lat_oe),
        .lat_dat (lat_dat),
        .so      (bnd_so)
    );

    bscan_aux #(.ID_VALUE(ID_VALUE)) u_aux (
        .clk     (tck),
        .rst     (trst),
        .byp_stb (byp_stb),
        .id_stb  (id_stb),
        .tdi     (tdi),
        .byp_so  (byp_so),
        .id_so   (id_so)
    );

    always_comb begin
        case (ins)
            INS_BYPASS: tdo = byp_so;
            INS_IDCODE: tdo = id_so;
            default:    tdo = bnd_so;
        endcase
    end

    assign ext_on  = (ins == INS_EXTEST) && !trst;
    assign pad_oe  = ext_on ? lat_oe  : core_oe;
    assign pad_out = ext_on ? lat_dat : core_out;
    assign core_in = ext_on ? {N_PINS{1'b1}} : pad_in;

endmodule

// File: tb/test_bscan_dr.sv
`timescale 1ns/1ps
module test_bscan_dr;
    localparam int          N  = 8;
    localparam int          W  = 2 * N;
    localparam logic [31:0] ID = 32'h4B1D_0E37;

    logic         tck = 1'b0;
    logic         trst;
    logic [1:0]   instr;
    logic         cap_dr, shift_dr, update_dr, tdi;
    logic         tdo;
    logic [N-1:0] core_oe, core_out, core_in, pad_in, pad_oe, pad_out;

    int n_checks = 0;
    int n_fail   = 0;

    bscan_dr #(.N_PINS(N), .ID_VALUE(ID)) i_bscan_dr (
        .tck(tck), .trst(trst), .instr(instr), .cap_dr(cap_dr),
        .shift_dr(shift_dr), .update_dr(update_dr), .tdi(tdi), .tdo(tdo),
        .core_oe(core_oe), .core_out(core_out), .core_in(core_in),
        .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #5 tck = ~tck;

    // behavioural reference model
    bit m_sr[W];
    bit m_lat[W];
    bit m_byp;
    bit m_id[$];
    bit m_prev[W];

    always @(posedge tck) begin
        if (trst) begin
            for (int i = 0; i < W; i++) begin m_sr[i] = 0; m_lat[i] = 0; end
            m_byp = 0;
            m_id.delete();
            for (int i = 0; i < 32; i++) m_id.push_back(1'b0);
        end else begin
            if (instr < 2) begin
                m_prev = m_sr;
                if (cap_dr) begin
                    for (int p = 0; p < N; p++) begin
                        m_sr[2*p] = core_oe[p]; m_sr[2*p+1] = pad_in[p];
                    end
                end else if (shift_dr) begin
                    for (int i = 0; i < W-1; i++) m_sr[i] = m_sr[i+1];
                    m_sr[W-1] = tdi;
                end
                if (update_dr) m_lat = m_prev;
            end else if (instr == 2) begin
                if (cap_dr) m_byp = 0; else if (shift_dr) m_byp = tdi;
            end else begin
                if (cap_dr) begin
                    m_id.delete();
                    for (int i = 0; i < 32; i++) m_id.push_back(i == 0 ? 1'b1 : ID[i]);
                end else if (shift_dr) begin
                    void'(m_id.pop_front());
                    m_id.push_back(tdi);
                end
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge tck) begin
        logic         e_tdo;
        logic [N-1:0] e_oe, e_out, e_in;
        bit           ext;
        ext = (instr == 0) && !trst;
        e_tdo = (instr == 2) ? m_byp : (instr == 3) ? m_id[0] : m_sr[0];
        for (int p = 0; p < N; p++) begin
            e_oe[p]  = ext ? m_lat[2*p]   : core_oe[p];
            e_out[p] = ext ? m_lat[2*p+1] : core_out[p];
            e_in[p]  = ext ? 1'b1 : pad_in[p];
        end
        if (!trst) check(tdo === e_tdo, "R2/R8/R9 tdo model", 32'(tdo), 32'(e_tdo));
        check(pad_oe === e_oe, "R4/R5 pad_oe model", 32'(pad_oe), 32'(e_oe));
        check(pad_out === e_out, "R4/R5 pad_out model", 32'(pad_out), 32'(e_out));
        check(core_in === e_in, "R6 core_in model", 32'(core_in), 32'(e_in));
    end

    task automatic cyc(input bit c, input bit s, input bit u, input bit d);
        cap_dr = c; shift_dr = s; update_dr = u; tdi = d;
        @(posedge tck); #2;
        cap_dr = 0; shift_dr = 0; update_dr = 0;
    endtask

    function automatic logic [W-1:0] weave(input logic [N-1:0] oe, input logic [N-1:0] dt);
        logic [W-1:0] v;
        for (int p = 0; p < N; p++) begin v[2*p] = oe[p]; v[2*p+1] = dt[p]; end
        return v;
    endfunction

    initial begin
        #100000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [W-1:0] cv, pv;
        trst = 1; instr = 2'd0; cap_dr = 0; shift_dr = 0; update_dr = 0; tdi = 0;
        core_oe = 8'hE1; core_out = 8'h7B; pad_in = 8'h44;
        repeat (3) @(posedge tck);
        #2;
        // R10: reset under EXTEST keeps the core in charge
        check(pad_oe === 8'hE1 && pad_out === 8'h7B, "R10 pins core-driven in reset",
              {pad_oe, pad_out}, {8'hE1, 8'h7B});
        check(core_in === 8'h44, "R10 core_in during reset", 32'(core_in), 32'h44);
        trst = 0;
        @(posedge tck); #2;
        check(pad_oe === 8'h00 && pad_out === 8'h00, "R10 latches cleared",
              {pad_oe, pad_out}, 0);

        // SAMPLE: capture, shift out, preset
        instr = 2'd1; core_oe = 8'hA5; core_out = 8'h19; pad_in = 8'h3C;
        cyc(1, 0, 0, 0);
        cv = weave(8'hA5, 8'h3C);
        pv = weave(8'h0F, 8'h96);
        for (int k = 0; k < W; k++) begin
            check(tdo === cv[k], "R1/R2 SAMPLE capture bit", 32'(tdo), 32'(cv[k]));
            cyc(0, 1, 0, pv[k]);
        end
        check(pad_oe === 8'hA5 && pad_out === 8'h19, "R5 SAMPLE pins follow core",
              {pad_oe, pad_out}, {8'hA5, 8'h19});
        check(core_in === 8'h3C, "R6 SAMPLE core_in from pins", 32'(core_in), 32'h3C);
        cyc(0, 0, 1, 0);
        check(pad_oe === 8'hA5 && pad_out === 8'h19, "R7 preset leaves pins alone",
              {pad_oe, pad_out}, {8'hA5, 8'h19});
        instr = 2'd0;
        #1;
        check(pad_oe === 8'h0F && pad_out === 8'h96, "R7/R4 EXTEST drives preset",
              {pad_oe, pad_out}, {8'h0F, 8'h96});
        check(core_in === 8'hFF, "R6 EXTEST core_in ones", 32'(core_in), 32'hFF);
        pad_in = 8'h00;
        #1;
        check(core_in === 8'hFF, "R6 EXTEST core_in ignores pins", 32'(core_in), 32'hFF);

        // EXTEST capture and reload
        pad_in = 8'h5A; core_oe = 8'hC3;
        @(posedge tck); #2;
        cyc(1, 0, 0, 0);
        cv = weave(8'hC3, 8'h5A);
        pv = weave(8'h33, 8'h55);
        for (int k = 0; k < W; k++) begin
            check(tdo === cv[k], "R1/R2 EXTEST capture bit", 32'(tdo), 32'(cv[k]));
            cyc(0, 1, 0, pv[k]);
            check(pad_oe === 8'h0F && pad_out === 8'h96, "R3 no ripple during shift",
                  {pad_oe, pad_out}, {8'h0F, 8'h96});
        end
        cyc(0, 0, 1, 0);
        check(pad_oe === 8'h33 && pad_out === 8'h55, "R3/R4 update drives pins",
              {pad_oe, pad_out}, {8'h33, 8'h55});

        // BYPASS
        instr = 2'd2;
        cyc(1, 0, 0, 1);
        check(tdo === 1'b0, "R8 bypass captures 0", 32'(tdo), 0);
        pv[3:0] = 4'b1101;
        for (int k = 0; k < 4; k++) begin
            cyc(0, 1, 0, pv[k]);
            check(tdo === pv[k], "R8 bypass one-bit delay", 32'(tdo), 32'(pv[k]));
        end
        cyc(0, 0, 1, 1);
        instr = 2'd0;
        #1;
        check(pad_oe === 8'h33 && pad_out === 8'h55, "R11 latches untouched by BYPASS",
              {pad_oe, pad_out}, {8'h33, 8'h55});
        check(tdo === 1'b1, "R11 boundary chain untouched by BYPASS", 32'(tdo), 1);

        // IDCODE
        instr = 2'd3;
        @(posedge tck); #2;
        cyc(1, 0, 0, 0);
        for (int k = 0; k < 32; k++) begin
            check(tdo === (k == 0 ? 1'b1 : ID[k]), "R9 IDCODE serial bit", 32'(tdo),
                  32'(k == 0 ? 1'b1 : ID[k]));
            cyc(0, 1, 0, 0);
        end
        check(tdo === 1'b0, "R9 ID register after full shift", 32'(tdo), 0);

        @(posedge tck); #2;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule